// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block joins two data ports, A and B, with one storage path in each direction. Each path can be transparent, where the far output follows the near input within the same cycle. It can hold, where the output shows a stored word. It can also load on an edge, where the stored word is replaced when the path's transfer clock rises. Each path has four controls of its own: an active-low output enable, a pass-through (latch) enable, a transfer clock and an active-low clock enable.

The transfer clocks are ordinary data inputs. They are sampled by the block's system clock `clk`, and a rising transfer-clock edge is found by comparing each sample with the one before it.

Tri-state pads are not built inside the block. Each port has a separate data input, a data output and a drive-enable output, and a pad wrapper outside the block builds the pin. Reset is synchronous and active high, and it clears both stored words.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's pass enable is 1 and its output enable is low, the far data output equals the near data input in the same cycle (A-to-B: `b_out == a_in`).
- R2: While the pass enable is 0 and no qualified rise occurs, the far output keeps the stored word. This holds whether the transfer clock stays low or stays high, and whatever the near input does.
- R3: A qualified rise happens in a cycle where the sampled transfer clock is 1, it was 0 at the previous `clk` edge, and the clock enable is 0. With pass enable 0, a qualified rise stores the near input at that `clk` edge, and the far output shows it from that edge on.
- R4: A rising transfer clock while the clock enable is 1 does not change the stored word.
- R5: When the pass enable drops from 1 to 0, the far output shows the near input that was present at the last `clk` edge with pass enable 1.
- R6: While the output enable is 1, the path's drive-enable output is 0 and its data output is all zeros. While the output enable is 0, the drive-enable output is 1.
- R7: The B-to-A path follows R1 to R6 with its own controls, and it is independent of the A-to-B path, including when both paths load in the same cycle.
- R8: A `clk` edge with `rst` high clears both stored words and the edge-detect history. Afterwards, a path with pass enable 0 and output enable 0 outputs all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all controls |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data received from the A pad |
| a_out | output | WIDTH | Data to drive onto the A pad |
| a_oe | output | 1 | Drive enable for the A pad |
| b_in | input | WIDTH | Data received from the B pad |
| b_out | output | WIDTH | Data to drive onto the B pad |
| b_oe | output | 1 | Drive enable for the B pad |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B pass enable |
| ab_clk | input | 1 | A-to-B transfer clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A pass enable |
| ba_clk | input | 1 | B-to-A transfer clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |

## Verification
Two pairs of events can fall in the same cycle. First, a qualified transfer-clock rise can come in the very cycle the pass enable falls, so the edge load and the end of transparency meet at one `clk` edge. Second, both directions can load at the same edge with different words. A directed step raises both transfer clocks together, and a long random run makes the first pairing often. Each case is judged against a bench model that applies pass-before-load priority and keeps the two paths apart.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_LOAD = 2'd2
    } xcvr_mode_e;

    // Pass enable outranks an edge load; otherwise hold.
    function automatic xcvr_mode_e pick_mode(input logic pass_en, input logic load);
        if (pass_en)
            return MODE_PASS;
        else if (load)
            return MODE_LOAD;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic tclk,
    input  logic ce_n,
    output logic load
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tclk;
        if (rst)
            st_d.prev = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load = tclk & ~st_q.prev & ~ce_n;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             pass_en,
    input  logic             tclk,
    input  logic             ce_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             doe
);
    import xcvr_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } lane_state_t;

    lane_state_t      st_d, st_q;
    logic             load;
    xcvr_mode_e       mode;
    logic [WIDTH-1:0] view;

    xcvr_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .tclk (tclk),
        .ce_n (ce_n),
        .load (load)
    );

    always_comb begin
        st_d = st_q;
        mode = pick_mode(pass_en, load);
        case (mode)
            MODE_PASS, MODE_LOAD: st_d.word = din;
            default:              st_d.word = st_q.word;
        endcase
        if (rst)
            st_d.word = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        view = (mode == MODE_PASS) ? din : st_q.word;
        dout = oe_n ? '0 : view;
        doe  = ~oe_n;
    end

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_oe_n,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ab_ce_n,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk,
    input  logic             ba_ce_n
);
    localparam int NDIR = 2;

    logic [WIDTH-1:0] lane_in  [NDIR];
    logic [WIDTH-1:0] lane_out [NDIR];
    logic [NDIR-1:0]  lane_oe;
    logic [NDIR-1:0]  lane_pass, lane_tclk, lane_ce_n, lane_oe_n;

    // Index 0: A to B, index 1: B to A.
    assign lane_in[0] = a_in;
    assign lane_in[1] = b_in;
    assign lane_pass  = {ba_le,   ab_le};
    assign lane_tclk  = {ba_clk,  ab_clk};
    assign lane_ce_n  = {ba_ce_n, ab_ce_n};
    assign lane_oe_n  = {ba_oe_n, ab_oe_n};

    for (genvar g = 0; g < NDIR; g++) begin : g_lane
        xcvr_lane #(.WIDTH(WIDTH)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .din     (lane_in[g]),
            .pass_en (lane_pass[g]),
            .tclk    (lane_tclk[g]),
            .ce_n    (lane_ce_n[g]),
            .oe_n    (lane_oe_n[g]),
            .dout    (lane_out[g]),
            .doe     (lane_oe[g])
        );
    end

    assign b_out = lane_out[0];
    assign b_oe  = lane_oe[0];
    assign a_out = lane_out[1];
    assign a_oe  = lane_oe[1];

endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ab_oe_n,
    input logic             ab_le,
    input logic             ab_clk,
    input logic             ab_ce_n,
    input logic             ba_oe_n,
    input logic             ba_le,
    input logic             ba_clk,
    input logic             ba_ce_n
);
    logic ab_seen, ba_seen;
    logic ab_qrise, ba_qrise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_seen <= 1'b0;
            ba_seen <= 1'b0;
        end else begin
            ab_seen <= ab_clk;
            ba_seen <= ba_clk;
        end
    end

    assign ab_qrise = ab_clk && !ab_seen && !ab_ce_n;
    assign ba_qrise = ba_clk && !ba_seen && !ba_ce_n;

    AST_AB_PASS: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_oe_n) |-> (b_out == a_in)); // R1
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !ab_qrise && !ab_oe_n) ##1 (!ab_le && !ab_oe_n) |-> $stable(b_out)); // R2
    AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && ab_qrise) ##1 (!ab_le && !ab_oe_n) |-> (b_out == $past(a_in))); // R3
    AST_AB_EXIT: assert property (@(posedge clk) disable iff (rst)
        ab_le ##1 (!ab_le && !ab_oe_n) |-> (b_out == $past(a_in))); // R5
    AST_AB_HIZ: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> (!b_oe && b_out == '0)); // R6
    AST_BA_PASS: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !ba_oe_n) |-> (a_out == b_in)); // R7
    AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && ba_qrise) ##1 (!ba_le && !ba_oe_n) |-> (a_out == $past(b_in))); // R7
    AST_BA_HIZ: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> (!a_oe && a_out == '0)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ab_le && !ab_oe_n) |-> (b_out == '0)); // R8

endmodule

bind bus_xcvr bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .ab_oe_n (ab_oe_n),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ab_ce_n (ab_ce_n),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .ba_ce_n (ba_ce_n)
);

// File: tb/bus_xcvr_test.sv
`timescale 1ns/1ps
module bus_xcvr_test;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din [2];
    logic [W-1:0] dout [2];
    logic         doe [2];
    logic         le [2], tck [2], cen [2], oen [2];
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] m_store [2];
    logic         m_prev [2];
    logic         m_loaded [2];

    always #4 clk = ~clk;

    bus_xcvr #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst),
        .a_in(din[0]), .a_out(a_out), .a_oe(a_oe),
        .b_in(din[1]), .b_out(b_out), .b_oe(b_oe),
        .ab_oe_n(oen[0]), .ab_le(le[0]), .ab_clk(tck[0]), .ab_ce_n(cen[0]),
        .ba_oe_n(oen[1]), .ba_le(le[1]), .ba_clk(tck[1]), .ba_ce_n(cen[1])
    );

    assign dout[0] = b_out;
    assign doe[0]  = b_oe;
    assign dout[1] = a_out;
    assign doe[1]  = a_oe;

    task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] expect_out(int d);
        if (oen[d]) return '0;
        if (le[d])  return din[d];
        return m_store[d];
    endfunction

    function automatic string tag_of(int d);
        if (d == 1)      return "R7";
        if (oen[d])      return "R6";
        if (le[d])       return "R1";
        if (m_loaded[d]) return "R3";
        return "R2";
    endfunction

    task automatic compare_all();
        for (int d = 0; d < 2; d++) begin
            check(dout[d], expect_out(d), tag_of(d));
            check(W'(doe[d]), W'(!oen[d]), (d == 1) ? "R7" : "R6");
        end
    endtask

    task automatic model_edge();
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                m_store[d]  = '0;
                m_prev[d]   = 1'b0;
                m_loaded[d] = 1'b0;
            end else begin
                m_loaded[d] = 1'b0;
                if (le[d])
                    m_store[d] = din[d];
                else if (tck[d] && !m_prev[d] && !cen[d]) begin
                    m_store[d]  = din[d];
                    m_loaded[d] = 1'b1;
                end
                m_prev[d] = tck[d];
            end
        end
    endtask

    // Called at a negedge with inputs already set.
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[W-1:0];
    endfunction

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] x4;
        void'($urandom(32'd2718));
        for (int d = 0; d < 2; d++) begin
            le[d] = 0; tck[d] = 0; cen[d] = 0; oen[d] = 0;
            din[d] = rnd_word();
            m_store[d] = '0; m_prev[d] = 0; m_loaded[d] = 0;
        end
        repeat (3) begin
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(b_out, '0, "R8");
        check(a_out, '0, "R8");
        step();

        // R1 pass-through
        le[0] = 1; din[0] = 18'h2A5A5;
        #1; check(b_out, 18'h2A5A5, "R1");
        step();
        // R5 leaving pass keeps last passed word
        din[0] = 18'h11111; step();
        le[0] = 0; din[0] = 18'h3C3C3;
        #1; check(b_out, 18'h11111, "R5");
        step();
        // R3 qualified rise loads
        tck[0] = 1; din[0] = 18'h0BEEF; x4 = 18'h0BEEF;
        step();
        #1; check(b_out, x4, "R3");
        // R2 hold with clock high, then low
        din[0] = 18'h12345; step();
        #1; check(b_out, x4, "R2");
        tck[0] = 0; step();
        #1; check(b_out, x4, "R2");
        // R4 rise while clock enable is high
        cen[0] = 1; tck[0] = 1; din[0] = 18'h2FFFF; step();
        #1; check(b_out, x4, "R4");
        // R7 both paths load in the same cycle; also pass ends at same edge
        cen[0] = 0; tck[0] = 0; le[1] = 1; step();
        tck[0] = 1; tck[1] = 1; le[1] = 0;
        din[0] = 18'h0AAAA; din[1] = 18'h15555; step();
        #1; check(b_out, 18'h0AAAA, "R3");
        check(a_out, 18'h15555, "R7");
        // R6 output enable high: no drive, zero data
        oen[0] = 1; oen[1] = 1; #1;
        check(W'(b_oe), '0, "R6"); check(b_out, '0, "R6");
        check(W'(a_oe), '0, "R7"); check(a_out, '0, "R7");
        step();

        for (int i = 0; i < 4000; i++) begin
            for (int d = 0; d < 2; d++) begin
                le[d]  = ($urandom % 4) == 0;
                tck[d] = ($urandom % 2) == 0;
                cen[d] = ($urandom % 4) == 0;
                oen[d] = ($urandom % 5) == 0;
                din[d] = rnd_word();
            end
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule